// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block keeps one interrupt flag and one interrupt enable per message buffer of a buffer-based communication controller. The buffer engine pulses a per-buffer strobe after each successful transmit or receive, which latches that buffer's flag. Software reads the flags and masks through a small register port. It clears flags by writing ones, and it gets a single registered interrupt request that is the OR of every flag whose enable is set.

Two mode inputs change how the flags behave. With abort mode on, any transmit buffer that has a pending flag drives its write-inhibit line, so the surrounding logic can refuse CPU writes to that buffer. With FIFO mode on, the low eight flag positions no longer belong to buffers. Bits 5, 6 and 7 report frame-available, almost-full and overflow conditions of the receive FIFO. Bits 0 to 4 stay at zero.

Top module: `mb_irq_flags`

## Requirements
- R1: After reset the mask register, the flag register, `irq` and every `wr_block` bit are 0.
- R2: Outside FIFO mode, a 1 on `buf_done[i]` at a clock edge sets flag bit i, and a read of address 1 shows it from that edge on.
- R3: A write to address 1 (flag register) clears every flag bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: If a set event and a write-one-to-clear reach the same flag bit in the same cycle, the bit ends up set.
- R5: Address 0 is the mask register. A write stores all NUM_BUF bits, a read returns them, and the register changes only on a write to address 0.
- R6: `irq` is 1 in the cycle after an edge at which some flag bit and its mask bit were both 1, and 0 otherwise. This includes mask changes on an already set flag.
- R7: `wr_block[i]` is `abort_mode & buf_is_tx[i] & flag[i]`, applied combinationally. In FIFO mode `wr_block[7:0]` are 0.
- R8: In FIFO mode, `fifo_avail` sets flag bit 5, `fifo_warn` sets bit 6 and `fifo_ovf` sets bit 7, and `buf_done[7:0]` is ignored. Outside FIFO mode the three FIFO strobes are ignored.
- R9: In FIFO mode, flag bits 4..0 read as 0, are held at 0 in storage and do not contribute to `irq`.
- R10: Addresses 2 and 3 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 flags, 2/3 reserved |
| reg_wdata | input | NUM_BUF | Write data |
| reg_rdata | output | NUM_BUF | Combinational read data for `reg_addr` |
| buf_done | input | NUM_BUF | Per-buffer successful transmit/receive strobes |
| fifo_avail | input | 1 | FIFO frame-available strobe |
| fifo_warn | input | 1 | FIFO almost-full strobe |
| fifo_ovf | input | 1 | FIFO overflow strobe |
| fifo_mode | input | 1 | FIFO mode enable |
| abort_mode | input | 1 | Abort mode enable |
| buf_is_tx | input | NUM_BUF | Per-buffer transmit configuration |
| wr_block | output | NUM_BUF | Per-buffer CPU write inhibit |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The bench walks a single event and a single clear across every one of the 32 positions. A design with a mis-wired bit, or one that clears on a written zero, shows a foreign or missing flag at that position. It collides a set with a clear on the same bit, which catches a design where the clear wins and an event is lost. It toggles a mask under a pending flag and checks `irq` one cycle later, which exposes missing registration or an AND with the wrong term. A long pseudo-random run switches both modes against an arithmetic model. That run finds low FIFO bits that still latch buffer events or leak into the interrupt, and write-inhibit bits that ignore abort mode, transmit type or the FIFO region.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } reg_sel_e;

  localparam int FIFO_REGION  = 8;  // low buffers taken over in FIFO mode
  localparam int FIFO_UNUSED  = 5;  // bits 0..4 idle in FIFO mode
  localparam int BIT_AVAIL    = 5;
  localparam int BIT_WARN     = 6;
  localparam int BIT_OVF      = 7;
endpackage

// File: rtl/mbif_mask_reg.sv
module mbif_mask_reg #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wdata,
  output logic [NUM_BUF-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end

  // R5: the mask moves only on its own write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank
  import mbif_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_avail,
  input  logic               fifo_warn,
  input  logic               fifo_ovf,
  input  logic [NUM_BUF-1:0] clr_vec,
  output logic [NUM_BUF-1:0] set_vec,
  output logic [NUM_BUF-1:0] flag_q,
  output logic [NUM_BUF-1:0] flag_eff
);
  // Route a hardware event source onto a flag position for the current mode
  function automatic logic event_for(input int idx, input logic fm,
                                     input logic done, input logic avail,
                                     input logic warn, input logic ovf);
    if (!fm || idx >= FIFO_REGION) return done;
    if (idx == BIT_AVAIL) return avail;
    if (idx == BIT_WARN)  return warn;
    if (idx == BIT_OVF)   return ovf;
    return 1'b0;
  endfunction

  function automatic logic idle_bit(input int idx, input logic fm);
    return fm && (idx < FIFO_UNUSED);
  endfunction

  logic [NUM_BUF-1:0] kill_vec;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    assign set_vec[i]  = event_for(i, fifo_mode, buf_done[i],
                                   fifo_avail, fifo_warn, fifo_ovf);
    assign kill_vec[i] = idle_bit(i, fifo_mode);
    assign flag_eff[i] = flag_q[i] & ~kill_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else flag_q[i] <= (set_vec[i] | (flag_q[i] & ~clr_vec[i])) & ~kill_vec[i];
    end
  end

  // R4: an event on a bit always leaves it set, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R3: a clear with no competing event leaves the bit at 0
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flag_q & $past(clr_vec & ~set_vec)) == '0));

  // R9: idle FIFO-mode bits are empty in storage after any FIFO-mode edge
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> (flag_q[FIFO_UNUSED-1:0] == '0));
endmodule

// File: rtl/mbif_irq_out.sv
module mbif_irq_out #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] flag_eff,
  input  logic [NUM_BUF-1:0] mask_q,
  output logic               irq_pend,
  output logic               irq
);
  assign irq_pend = |(flag_eff & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= irq_pend;
  end
endmodule

// File: rtl/mb_irq_flags.sv
module mb_irq_flags
  import mbif_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_BUF-1:0] reg_wdata,
  output logic [NUM_BUF-1:0] reg_rdata,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_avail,
  input  logic               fifo_warn,
  input  logic               fifo_ovf,
  input  logic               fifo_mode,
  input  logic               abort_mode,
  input  logic [NUM_BUF-1:0] buf_is_tx,
  output logic [NUM_BUF-1:0] wr_block,
  output logic               irq
);
  localparam int LOW_W = FIFO_REGION;

  logic [NUM_BUF-1:0] mask_q, flag_q, flag_eff, set_vec, clr_vec;
  logic [NUM_BUF-1:0] fifo_area;
  logic               mask_wr, flag_wr, irq_pend;

  assign mask_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);
  assign flag_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_FLAG);
  assign clr_vec = flag_wr ? reg_wdata : '0;

  mbif_mask_reg #(.NUM_BUF(NUM_BUF)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(reg_wdata), .mask_q(mask_q)
  );

  mbif_flag_bank #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .buf_done(buf_done),
    .fifo_avail(fifo_avail), .fifo_warn(fifo_warn), .fifo_ovf(fifo_ovf),
    .clr_vec(clr_vec), .set_vec(set_vec), .flag_q(flag_q), .flag_eff(flag_eff)
  );

  mbif_irq_out #(.NUM_BUF(NUM_BUF)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag_eff(flag_eff), .mask_q(mask_q),
    .irq_pend(irq_pend), .irq(irq)
  );

  // Low region belongs to the FIFO while FIFO mode is on
  assign fifo_area = fifo_mode ? {{(NUM_BUF-LOW_W){1'b0}}, {LOW_W{1'b1}}} : '0;
  assign wr_block  = abort_mode ? (buf_is_tx & flag_eff & ~fifo_area) : '0;

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_MASK: reg_rdata = mask_q;
      SEL_FLAG: reg_rdata = flag_eff;
      default:  reg_rdata = '0;
    endcase
  end

  // R6: the request follows the enabled-flag OR one cycle later
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> irq);
  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |=> !irq);

  // R7: an inhibited buffer must hold a pending flag
  a_r7_block_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block & ~flag_q) == '0);
endmodule

// File: tb/tb_mb_irq_flags.sv
module tb_mb_irq_flags;
  localparam int NB = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 0, rst_n = 0;
  logic          reg_wr = 0;
  logic [1:0]    reg_addr = 0;
  logic [NB-1:0] reg_wdata = 0, reg_rdata;
  logic [NB-1:0] buf_done = 0, buf_is_tx = 0, wr_block;
  logic          fifo_avail = 0, fifo_warn = 0, fifo_ovf = 0;
  logic          fifo_mode = 0, abort_mode = 0, irq;

  int checks = 0, fails = 0;
  logic [NB-1:0] m_flag = 0, m_mask = 0;
  logic          m_irq = 0;
  bit            done_flag = 0;

  mb_irq_flags #(.NUM_BUF(NB)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NB-1:0] visible(input logic [NB-1:0] f, input logic fm);
    return fm ? (f & ~32'h0000_001F) : f;
  endfunction

  function automatic logic [NB-1:0] exp_block();
    logic [NB-1:0] b = abort_mode ? (buf_is_tx & visible(m_flag, fifo_mode)) : '0;
    if (fifo_mode) b = b & 32'hFFFF_FF00;
    return b;
  endfunction

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: model advances from the inputs held across the edge
  task automatic cyc();
    logic [NB-1:0] ev, clr, nf;
    ev = buf_done;
    if (fifo_mode) begin
      ev[7:0] = 8'h00;
      ev[5] = fifo_avail; ev[6] = fifo_warn; ev[7] = fifo_ovf;
    end
    clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
    nf = (m_flag & ~clr) | ev;
    if (fifo_mode) nf[4:0] = 5'b0;
    @(posedge clk);
    if (rst_n) begin
      m_irq = (visible(m_flag, fifo_mode) & m_mask) != '0;
      if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata;
      m_flag = nf;
    end
    #1;
    reg_wr = 0; buf_done = 0; fifo_avail = 0; fifo_warn = 0; fifo_ovf = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NB-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  task automatic rd(input logic [1:0] a, output logic [NB-1:0] d);
    reg_wr = 0; reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [NB-1:0] d;
    rd(2'd1, d); chk({req, " flags"}, d, visible(m_flag, fifo_mode));
    rd(2'd0, d); chk({req, " mask"}, d, m_mask);
    chk({req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    chk({req, " wr_block"}, wr_block, exp_block());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] d;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    abort_mode = 1; buf_is_tx = '1;
    check_all("R1");
    rst_n = 1; #1;
    cyc();
    check_all("R1");

    // R2, R3: walk every position; R6: mask on pending flag
    for (int i = 0; i < NB; i++) begin
      abort_mode = 0;
      buf_done = NB'(1) << i; cyc();
      rd(2'd1, d); chk("R2 single set", d, NB'(1) << i);
      wr(2'd1, ~(NB'(1) << i));
      rd(2'd1, d); chk("R3 zeros keep", d, NB'(1) << i);
      wr(2'd0, NB'(1) << i);
      cyc(); chk("R6 mask raise", {31'b0, irq}, 32'd1);
      wr(2'd0, '0);
      cyc(); chk("R6 mask drop", {31'b0, irq}, 32'd0);
      abort_mode = 1; buf_is_tx = NB'(1) << i; #1;
      chk("R7 block", wr_block, NB'(1) << i);
      buf_is_tx = 0; #1;
      chk("R7 rx no block", wr_block, '0);
      wr(2'd1, NB'(1) << i);
      rd(2'd1, d); chk("R3 clear", d, '0);
    end

    // R4: set beats clear in the same cycle
    buf_done = 32'h0001_0200; reg_wr = 1; reg_addr = 2'd1; reg_wdata = '1;
    cyc();
    rd(2'd1, d); chk("R4 set wins", d, 32'h0001_0200);
    wr(2'd1, '1);

    // R10: reserved addresses
    wr(2'd2, '1); wr(2'd3, '1);
    rd(2'd2, d); chk("R10 addr2", d, '0);
    rd(2'd3, d); chk("R10 addr3", d, '0);
    check_all("R10 regs untouched");

    // R8, R9: FIFO mode sources
    fifo_mode = 1; buf_done = 32'h0000_01FF; fifo_avail = 1; cyc();
    rd(2'd1, d); chk("R8 avail+ignore low done", d, 32'h0000_0120);
    fifo_warn = 1; cyc();
    fifo_ovf = 1; cyc();
    rd(2'd1, d); chk("R8 warn/ovf", d, 32'h0000_01E0);
    abort_mode = 1; buf_is_tx = '1; #1;
    chk("R7 fifo area unblocked", wr_block, 32'h0000_0100);
    fifo_mode = 0; fifo_ovf = 1; cyc(); fifo_mode = 1;
    wr(2'd1, '1); fifo_mode = 0;
    fifo_avail = 1; fifo_warn = 1; cyc();
    rd(2'd1, d); chk("R8 strobes ignored outside FIFO", d, '0);
    buf_done = 32'h0000_001F; cyc();
    wr(2'd0, 32'h0000_001F);
    fifo_mode = 1; #1;
    rd(2'd1, d); chk("R9 low reads 0", d, '0);
    cyc(); cyc();
    chk("R9 no irq from idle bits", {31'b0, irq}, 32'd0);
    fifo_mode = 0; #1;
    rd(2'd1, d); chk("R9 storage cleared", d, '0);
    check_all("R9");

    // Pseudo-random sweep against the model
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      buf_done   = lfsr & {lfsr[15:0], lfsr[31:16]} & {lfsr[7:0], lfsr[31:8]};
      fifo_avail = lfsr[3]; fifo_warn = lfsr[9] & lfsr[2]; fifo_ovf = lfsr[17] & lfsr[4];
      if (lfsr[27:24] == 4'h0) fifo_mode = ~fifo_mode;
      if (lfsr[23:20] == 4'h1) abort_mode = ~abort_mode;
      buf_is_tx  = {lfsr[12:0], lfsr[31:13]};
      reg_wr     = lfsr[30] | lfsr[11];
      reg_addr   = lfsr[19:18];
      reg_wdata  = lfsr[29] ? {lfsr[5:0], lfsr[31:6]} : ({lfsr[20:0], lfsr[31:21]} & lfsr);
      cyc();
      check_all("R2/R3/R5/R6/R7/R8/R9 sweep");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule